// File: doc/BRIEF.md
# Prescaled External Event Counter Timer

This block counts edges on an asynchronous external count input and divides that count through two reloadable 8-bit down-counters in series. The first stage is a prescaler. Each time it passes zero it reloads and moves the second stage, the main timer, down by one. When the main timer passes zero it also reloads and raises a one-clock timer interrupt. With a prescaler setting n and a timer setting m, one timer interrupt is raised for every (n+1)×(m+1) counted edges.

The count input passes through a two-flop synchroniser and a single-bit edge detector. A polarity bit in the mode register chooses whether rising or falling edges are counted. The same edge raises a one-clock edge interrupt every time it occurs, whether or not counting is enabled. Software reaches a mode register, the prescaler and the timer through a byte-wide register port. A write completes in the cycle it is presented and never stalls. A read returns the live value of the addressed register with no wait. No data stream passes through the block, so none of its pins uses a valid/ready handshake.

Top module: `evt_prescale_timer`

## Requirements
- R1: After reset, the mode register, prescaler count and timer count all read 0x00, and both edge_irq and tmr_irq are low.
- R2: Addresses decode as follows: 0 selects the mode register, 1 the prescaler and 2 the timer. Reads at 1 and 2 return the current count. Mode bits 7:6 always read 0, and address 3 reads 0 and ignores writes.
- R3: A write to the prescaler or the timer loads the written value into that stage's reload register and into its counter in the same cycle.
- R4: Mode bit 2 selects the counted edge of cnt_in: 0 selects rising edges and 1 selects falling edges. The other edge never changes a count.
- R5: Counting happens only while mode bits 1:0 equal 2'b10 and mode bit 3 is 1. Otherwise both counts hold.
- R6: Each counted edge decrements the prescaler. A counted edge that finds the prescaler at 0 reloads it and, in the same cycle, decrements the timer, or reloads the timer if the timer is at 0. This divides the edge count by (n+1)×(m+1).
- R7: tmr_irq is a one-clock pulse, raised in the clock after the cycle in which the timer passes zero.
- R8: edge_irq is a one-clock pulse for each selected edge of cnt_in, whether or not counting is enabled. It is raised on the third rising clock edge after cnt_in changes.
- R9: A register write in the same cycle as a count event wins, and that count event is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 prescaler, 2 timer) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| cnt_in | input | 1 | Asynchronous external count input |
| edge_irq | output | 1 | One-clock pulse on each selected edge |
| tmr_irq | output | 1 | One-clock pulse when the timer passes zero |

## Verification
The bench drives full pulses on cnt_in against the rising polarity and checks that settings of 2 and 1 give no timer interrupt after five edges and exactly one after the sixth, which confirms the (n+1)×(m+1) cascade. Under falling polarity it drives half pulses, which separates the counted edge from the ignored one. It then drives pulses with counting stopped and with a wrong mode code, which shows that the edge interrupt still fires while the counts hold. A write timed to meet a detected edge exactly shows whether the write or the count wins.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_PRE  = 2'd1,
    A_TMR  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  localparam logic [1:0] MODE_EVENT = 2'b10;
  localparam int MODE_BITS = 6;
  localparam int BIT_POL   = 2;
  localparam int BIT_RUN   = 3;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              s_cur;

  assign s_cur = sh_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= s_cur;
    end
  end

  assign rise = s_cur & ~prev_q;
  assign fall = ~s_cur & prev_q;
endmodule

// File: rtl/evt_down_stage.sv
module evt_down_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         uflow
);
  logic [W-1:0] rld_q;

  assign uflow = en && !ld && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      rld_q <= '0;
    end else if (ld) begin
      rld_q <= ld_val;
      cnt   <= ld_val;
    end else if (en) begin
      cnt <= (cnt == '0) ? rld_q : cnt - 1'b1;
    end
  end

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && cnt == '0) |=> (cnt == $past(rld_q))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt)); // R5
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)) && (rld_q == $past(ld_val))); // R3
endmodule

// File: rtl/evt_prescale_timer.sv
module evt_prescale_timer
  import evt_tmr_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          cnt_in,
  output logic          edge_irq,
  output logic          tmr_irq
);
  logic [MODE_BITS-1:0] mode_q;
  logic                 wr_mode, wr_pre, wr_tmr;
  logic                 rise, fall, sel_edge, run, cnt_evt;
  logic [CW-1:0]        pre_cnt, tmr_cnt;
  logic                 pre_uf, tmr_uf;

  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_pre  = reg_we && (reg_addr == A_PRE);
  assign wr_tmr  = reg_we && (reg_addr == A_TMR);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_mode) mode_q <= reg_wdata[MODE_BITS-1:0];
  end

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_in), .rise(rise), .fall(fall)
  );

  assign sel_edge = mode_q[BIT_POL] ? fall : rise;
  assign run      = (mode_q[1:0] == MODE_EVENT) && mode_q[BIT_RUN];
  // any register write in this cycle drops the count event
  assign cnt_evt  = sel_edge && run && !reg_we;

  evt_down_stage #(.W(CW)) u_pre (
    .clk(clk), .rst_n(rst_n), .ld(wr_pre), .ld_val(reg_wdata),
    .en(cnt_evt), .cnt(pre_cnt), .uflow(pre_uf)
  );

  evt_down_stage #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(wr_tmr), .ld_val(reg_wdata),
    .en(pre_uf), .cnt(tmr_cnt), .uflow(tmr_uf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_irq <= 1'b0;
      tmr_irq  <= 1'b0;
    end else begin
      edge_irq <= sel_edge;
      tmr_irq  <= tmr_uf;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_MODE:  reg_rdata = CW'(mode_q);
      A_PRE:   reg_rdata = pre_cnt;
      A_TMR:   reg_rdata = tmr_cnt;
      default: reg_rdata = '0;
    endcase
  end

  AST_EDGE_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq |=> !edge_irq); // R8
  AST_TMR_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> $past(pre_uf)); // R7
  AST_WRITE_DROPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != A_PRE) |=> $stable(pre_cnt)); // R9
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_pre) |=> $stable(pre_cnt)); // R5
endmodule

// File: tb/sim_evt_prescale_timer.sv
`timescale 1ns/1ps
module sim_evt_prescale_timer;
  logic       clk = 1'b0;
  logic       rst_n, reg_we, cnt_in;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       edge_irq, tmr_irq;
  int n_chk = 0, n_fail = 0, n_edge = 0, n_tmr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_prescale_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_in(cnt_in),
    .edge_irq(edge_irq), .tmr_irq(tmr_irq)
  );

  always @(negedge clk) begin
    if (rst_n && edge_irq) n_edge++;
    if (rst_n && tmr_irq)  n_tmr++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); cnt_in = 1'b1; repeat (5) @(negedge clk);
    cnt_in = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 edge_irq", edge_irq, 0); chk("R1 tmr_irq", tmr_irq, 0);
    rd(0, v); chk("R1 mode", v, 0);
    rd(1, v); chk("R1 prescaler", v, 0);
    rd(2, v); chk("R1 timer", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(0, 8'hC2); rd(0, v); chk("R2 mode bits 7:6 read 0", v, 8'h02);
    wr(3, 8'h55); rd(3, v); chk("R2 unused address", v, 0);
    rd(0, v); chk("R2 mode untouched by addr 3", v, 8'h02);
    wr(1, 8'd2); wr(2, 8'd1);
    rd(1, v); chk("R3 prescaler load", v, 2);
    rd(2, v); chk("R3 timer load", v, 1);
  endtask

  task automatic t_rising();
    int v, e0, t0;
    wr(0, 8'h0A); e0 = n_edge; t0 = n_tmr;
    for (int i = 0; i < 5; i++) pulse();
    rd(1, v); chk("R6 prescaler after 5", v, 0);
    rd(2, v); chk("R6 timer after 5", v, 0);
    chk("R7 no timer irq after 5", n_tmr - t0, 0);
    chk("R8 edge irqs rising", n_edge - e0, 5);
    pulse();
    chk("R7 one timer irq after 6", n_tmr - t0, 1);
    rd(1, v); chk("R6 prescaler reloaded", v, 2);
    rd(2, v); chk("R6 timer reloaded", v, 1);
  endtask

  task automatic t_falling();
    int v, e0, t0;
    wr(1, 8'd1); wr(2, 8'd0); wr(0, 8'h0E); e0 = n_edge; t0 = n_tmr;
    @(negedge clk); cnt_in = 1'b1; repeat (6) @(negedge clk);
    rd(1, v); chk("R4 rise ignored when falling selected", v, 1);
    chk("R4 no edge irq on rise", n_edge - e0, 0);
    cnt_in = 1'b0; repeat (6) @(negedge clk);
    rd(1, v); chk("R4 fall counted", v, 0);
    chk("R8 edge irq on fall", n_edge - e0, 1);
    pulse();
    rd(1, v); chk("R6 prescaler reload falling", v, 1);
    chk("R7 timer irq falling", n_tmr - t0, 1);
  endtask

  task automatic t_stop();
    int v, e0;
    wr(1, 8'd3); wr(2, 8'd3); wr(0, 8'h02); e0 = n_edge;
    for (int i = 0; i < 3; i++) pulse();
    rd(1, v); chk("R5 stopped prescaler holds", v, 3);
    chk("R8 edge irq while stopped", n_edge - e0, 3);
    wr(0, 8'h0B);
    for (int i = 0; i < 2; i++) pulse();
    rd(1, v); chk("R5 wrong mode holds", v, 3);
    rd(2, v); chk("R5 wrong mode timer holds", v, 3);
  endtask

  task automatic t_collide();
    int v;
    wr(1, 8'd4); wr(2, 8'd7); wr(0, 8'h0A);
    @(negedge clk); cnt_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'd5;
    @(negedge clk); reg_we = 1'b0;
    repeat (4) @(negedge clk); cnt_in = 1'b0; repeat (5) @(negedge clk);
    rd(2, v); chk("R9 write kept", v, 5);
    rd(1, v); chk("R9 colliding event dropped", v, 4);
    pulse();
    rd(1, v); chk("R9 counting resumes", v, 3);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; cnt_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset(); t_regs(); t_rising(); t_falling(); t_stop(); t_collide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule